// File: doc/BRIEF.md
# I2C Master Receive Acknowledge Controller

This block is the byte-level receive path of an I2C master. A bit engine, which owns SCL and SDA timing, hands it one received data bit per strobe. The block assembles these bits into bytes, MSB first. After each byte it decides whether the acknowledge slot carries ACK or NACK, and it reports that decision back to the bit engine. Each completed byte moves into a data holding register that the host reads. If the holding register is still full when the next byte completes, that byte waits in a second stage, a byte-transfer-finished flag rises, and the block asks the bit engine to hold the bus.

The host steers the end of a read through the block's control inputs:

- An acknowledge-enable bit selects ACK or NACK for the bytes still to come.
- A delayed-acknowledge bit makes the acknowledge decision one byte late, so that a two-byte read can be set up before the first byte arrives.
- STOP and repeated-START requests are deferred until the byte in flight, or the byte waiting behind a full holding register, has been dealt with.

The same control inputs support reads of one byte, two bytes, and three or more bytes, each finished with a NACK on the last byte followed by a STOP or a repeated START.

Top module: `i2c_mrx_ack`

## Requirements
- R1: `ack_stb` pulses for one cycle in the cycle after the edge that takes the eighth bit of a byte. `ack_nack` then gives the slot value, where 1 means NACK and 0 means ACK. While `pos_q` is 0 the value is the inverse of `ack_en_q` at that edge.
- R2: While `pos_q` is 1, a byte's acknowledge comes from `ack_en_q` as it stood when the previous byte completed. The first byte after reset, after enable, or after a STOP or repeated START is always acknowledged.
- R3: A completed byte whose holding register is empty is moved there, and `rxne` rises in the next cycle. `dr_data` shows the byte, where the first bit received is bit 7.
- R4: A byte that completes while `rxne` is 1 is parked in the second stage. `btf` and `hold_scl` rise, and `bit_stb` pulses are ignored while `hold_scl` is 1.
- R5: A `dr_rd` pulse while `rxne` is 1 does one of two things. If `btf` is 0, it clears `rxne`. If `btf` is 1, it moves the parked byte into `dr_data`, keeps `rxne` at 1, and clears `btf` and `hold_scl`.
- R6: A STOP or repeated-START request produces a one-cycle `gen_stop` or `gen_restart` pulse in one of two places. Normally the pulse comes one cycle after the next byte completes. If `btf` was 1 when the request was made, the pulse comes one cycle after the read that clears `btf`. A pending STOP takes priority over a pending repeated START, and the two pulses never coincide.
- R7: For a single-byte read, the host sets acknowledge-enable and the delayed bit to 0 and requests STOP before the byte arrives. The byte is then NACKed, and the STOP pulse follows it.
- R8: For a read of three or more bytes, the host clears acknowledge-enable while `btf` is 1 with three bytes left unread, then performs the reads. Only the final byte is NACKed, and the STOP pulse follows the first of the last two reads.
- R9: `pos_q` is 0 whenever `gen_stop` or `gen_restart` is high. Deasserting `enable` clears `pos_q`, `ack_en_q`, `rxne` and `btf`.
- R10: After reset, `rxne`, `btf`, `hold_scl`, `ack_stb`, `gen_stop`, `gen_restart`, `ack_en_q`, `pos_q` and `dr_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low clears all state |
| bit_stb | input | 1 | One received data bit is valid |
| bit_in | input | 1 | Received data bit |
| hold_scl | output | 1 | Request to the bit engine to stall the bus |
| ack_stb | output | 1 | Acknowledge slot decision valid |
| ack_nack | output | 1 | 1 = NACK, 0 = ACK |
| gen_stop | output | 1 | Generate a STOP condition now |
| gen_restart | output | 1 | Generate a repeated START now |
| ctl_wr | input | 1 | Write the two control bits |
| ctl_ack_en | input | 1 | Acknowledge-enable value to write |
| ctl_pos | input | 1 | Delayed-acknowledge value to write |
| req_stop | input | 1 | Request a STOP after the current byte |
| req_restart | input | 1 | Request a repeated START after the current byte |
| dr_rd | input | 1 | Host read of the holding register |
| dr_data | output | DATA_W | Holding register contents |
| rxne | output | 1 | Holding register full |
| btf | output | 1 | Byte waiting behind a full holding register |
| ack_en_q | output | 1 | Current acknowledge-enable bit |
| pos_q | output | 1 | Current delayed-acknowledge bit |

## Verification
The bench builds the block with its default 8-bit byte width and plays a target that sends one to six bytes. For each length it runs the host sequence the requirements prescribe, ending in STOP, in repeated START, or in both requested together. This brings within reach every position at which the acknowledge can turn to NACK, the one-byte-late decision, and the parked second byte. It also reaches the deferral of the STOP or restart past a stalled bus. Bit strobes sent while the bus is held, a premature look for the STOP pulse, and a disable with both control bits set are also exercised.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;

    typedef enum logic [1:0] {
        COND_NONE    = 2'd0,
        COND_STOP    = 2'd1,
        COND_RESTART = 2'd2
    } cond_e;

    typedef struct packed {
        logic stb;
        logic nack;
    } ack_t;

    // Acknowledge slot value: 1 = NACK. With the delayed bit set the
    // decision comes from the value saved at the previous byte.
    function automatic logic pick_nack(input logic dly, input logic saved, input logic live);
        return dly ? !saved : !live;
    endfunction

endpackage

// File: rtl/i2c_mrx_shift.sv
module i2c_mrx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              held,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-2:0] sh_q;
    logic              take;

    assign take      = bit_stb && !held;
    assign byte_done = take && (cnt_q == LAST);
    assign byte_val  = {sh_q, bit_in};

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (take) begin
            sh_q  <= byte_val[DATA_W-2:0];
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_mrx_ackpol.sv
module i2c_mrx_ackpol
    import i2c_mrx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ctl_wr,
    input  logic ctl_ack_en,
    input  logic ctl_pos,
    input  logic byte_done,
    input  logic cond_fire,
    output logic ack_en_q,
    output logic pos_q,
    output logic nack_now
);
    logic saved_q;

    assign nack_now = pick_nack(pos_q, saved_q, ack_en_q);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            ack_en_q <= 1'b0;
            pos_q    <= 1'b0;
            saved_q  <= 1'b1;
        end else begin
            if (ctl_wr)
                ack_en_q <= ctl_ack_en;
            if (cond_fire)
                pos_q <= 1'b0;
            else if (ctl_wr)
                pos_q <= ctl_pos;
            if (cond_fire)
                saved_q <= 1'b1;
            else if (byte_done)
                saved_q <= ack_en_q;
        end
    end
endmodule

// File: rtl/i2c_mrx_hold.sv
module i2c_mrx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_val,
    input  logic              dr_rd,
    output logic [DATA_W-1:0] dr_data,
    output logic              rxne,
    output logic              btf
);
    logic [DATA_W-1:0] park_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            dr_data <= '0;
            park_q  <= '0;
            rxne    <= 1'b0;
            btf     <= 1'b0;
        end else if (dr_rd && rxne) begin
            if (btf) begin
                dr_data <= park_q;
                btf     <= 1'b0;
            end else if (byte_done) begin
                dr_data <= byte_val;
            end else begin
                rxne <= 1'b0;
            end
        end else if (byte_done) begin
            if (!rxne) begin
                dr_data <= byte_val;
                rxne    <= 1'b1;
            end else begin
                park_q <= byte_val;
                btf    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_mrx_cond.sv
module i2c_mrx_cond
    import i2c_mrx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic req_stop,
    input  logic req_restart,
    input  logic byte_done,
    input  logic btf,
    output logic cond_fire,
    output logic gen_stop,
    output logic gen_restart
);
    logic  want_stop_q, want_rs_q, armed_q;
    logic  any_want;
    cond_e out_q;

    assign any_want    = want_stop_q || want_rs_q;
    assign cond_fire   = any_want && armed_q && !btf;
    assign gen_stop    = (out_q == COND_STOP);
    assign gen_restart = (out_q == COND_RESTART);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            want_stop_q <= 1'b0;
            want_rs_q   <= 1'b0;
            armed_q     <= 1'b0;
            out_q       <= COND_NONE;
        end else if (cond_fire) begin
            out_q       <= want_stop_q ? COND_STOP : COND_RESTART;
            want_stop_q <= req_stop;
            want_rs_q   <= req_restart;
            armed_q     <= 1'b0;
        end else begin
            out_q <= COND_NONE;
            if (req_stop)
                want_stop_q <= 1'b1;
            if (req_restart)
                want_rs_q <= 1'b1;
            if ((any_want || req_stop || req_restart) && (byte_done || btf))
                armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_mrx_ack.sv
module i2c_mrx_ack
    import i2c_mrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bit_stb,
    input  logic              bit_in,
    output logic              hold_scl,
    output logic              ack_stb,
    output logic              ack_nack,
    output logic              gen_stop,
    output logic              gen_restart,
    input  logic              ctl_wr,
    input  logic              ctl_ack_en,
    input  logic              ctl_pos,
    input  logic              req_stop,
    input  logic              req_restart,
    input  logic              dr_rd,
    output logic [DATA_W-1:0] dr_data,
    output logic              rxne,
    output logic              btf,
    output logic              ack_en_q,
    output logic              pos_q
);
    logic              byte_done, nack_now, cond_fire;
    logic [DATA_W-1:0] byte_val;
    ack_t              ack_q;

    assign hold_scl = btf;
    assign ack_stb  = ack_q.stb;
    assign ack_nack = ack_q.nack;

    i2c_mrx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .enable(enable),
        .bit_stb(bit_stb), .bit_in(bit_in), .held(btf),
        .byte_done(byte_done), .byte_val(byte_val)
    );

    i2c_mrx_ackpol u_pol (
        .clk(clk), .rst(rst), .enable(enable),
        .ctl_wr(ctl_wr), .ctl_ack_en(ctl_ack_en), .ctl_pos(ctl_pos),
        .byte_done(byte_done), .cond_fire(cond_fire),
        .ack_en_q(ack_en_q), .pos_q(pos_q), .nack_now(nack_now)
    );

    i2c_mrx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .enable(enable),
        .byte_done(byte_done), .byte_val(byte_val), .dr_rd(dr_rd),
        .dr_data(dr_data), .rxne(rxne), .btf(btf)
    );

    i2c_mrx_cond u_cond (
        .clk(clk), .rst(rst), .enable(enable),
        .req_stop(req_stop), .req_restart(req_restart),
        .byte_done(byte_done), .btf(btf),
        .cond_fire(cond_fire), .gen_stop(gen_stop), .gen_restart(gen_restart)
    );

    always_ff @(posedge clk) begin
        if (rst || !enable)
            ack_q <= '0;
        else
            ack_q <= '{stb: byte_done, nack: nack_now};
    end
endmodule

// File: rtl/i2c_mrx_ack_chk.sv
module i2c_mrx_ack_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic bit_stb,
    input logic ack_stb,
    input logic rxne,
    input logic btf,
    input logic dr_rd,
    input logic gen_stop,
    input logic gen_restart,
    input logic pos_q
);
    p_ack_after_bit_r1: assert property (@(posedge clk) disable iff (rst)
        ack_stb |-> $past(bit_stb));

    p_btf_needs_rxne_r4: assert property (@(posedge clk) disable iff (rst)
        btf |-> rxne);

    p_btf_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(btf) |-> ($past(rxne) && $past(bit_stb)));

    p_rxne_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rxne) |-> ($past(dr_rd) || !$past(enable)));

    p_cond_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gen_stop, gen_restart}));

    p_pos_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (gen_stop || gen_restart) |-> !pos_q);
endmodule

bind i2c_mrx_ack i2c_mrx_ack_chk u_chk (
    .clk(clk), .rst(rst), .enable(enable), .bit_stb(bit_stb),
    .ack_stb(ack_stb), .rxne(rxne), .btf(btf), .dr_rd(dr_rd),
    .gen_stop(gen_stop), .gen_restart(gen_restart), .pos_q(pos_q)
);

// File: tb/i2c_mrx_ack_test.sv
module i2c_mrx_ack_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       bit_stb = 1'b0, bit_in = 1'b0;
    logic       ctl_wr = 1'b0, ctl_ack_en = 1'b0, ctl_pos = 1'b0;
    logic       req_stop = 1'b0, req_restart = 1'b0, dr_rd = 1'b0;
    logic       hold_scl, ack_stb, ack_nack, gen_stop, gen_restart;
    logic       rxne, btf, ack_en_q, pos_q;
    logic [7:0] dr_data;

    int n_chk = 0, n_fail = 0;
    int ack_n = 0, stop_n = 0, rs_n = 0;
    logic ack_log [0:255];
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_mrx_ack #(.DATA_W(8)) uut (
        .clk(clk), .rst(rst), .enable(enable), .bit_stb(bit_stb), .bit_in(bit_in),
        .hold_scl(hold_scl), .ack_stb(ack_stb), .ack_nack(ack_nack),
        .gen_stop(gen_stop), .gen_restart(gen_restart),
        .ctl_wr(ctl_wr), .ctl_ack_en(ctl_ack_en), .ctl_pos(ctl_pos),
        .req_stop(req_stop), .req_restart(req_restart), .dr_rd(dr_rd),
        .dr_data(dr_data), .rxne(rxne), .btf(btf), .ack_en_q(ack_en_q), .pos_q(pos_q)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ack_stb) begin
                ack_log[ack_n[7:0]] = ack_nack;
                ack_n = ack_n + 1;
            end
            if (gen_stop) stop_n = stop_n + 1;
            if (gen_restart) rs_n = rs_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int n, input int k);
        return 8'(8'h3C + n * 8'h1D + k * 8'h47);
    endfunction

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            bit_stb = 1'b1;
            bit_in  = b[i];
            tick;
        end
        bit_stb = 1'b0;
        bit_in  = 1'b0;
    endtask

    task automatic host_read(input string req, input logic [7:0] exp);
        dr_rd = 1'b1;
        chk(req, int'(dr_data), int'(exp));
        tick;
        dr_rd = 1'b0;
    endtask

    task automatic write_ctl(input logic a, input logic p);
        ctl_wr = 1'b1; ctl_ack_en = a; ctl_pos = p;
        tick;
        ctl_wr = 1'b0;
    endtask

    // mode 0: STOP, 1: repeated START, 2: both requested (STOP wins)
    task automatic request(input int mode);
        req_stop    = (mode != 1);
        req_restart = (mode != 0);
        tick;
        req_stop    = 1'b0;
        req_restart = 1'b0;
    endtask

    task automatic run_read(input int n, input int mode);
        int    ab, sb, rb;
        string tag;
        tag = (n == 1) ? "R7" : (n == 2) ? "R2" : "R8";
        ab = ack_n; sb = stop_n; rb = rs_n;
        if (n == 1) begin
            write_ctl(1'b0, 1'b0);
            request(mode);
            tick; tick; #1;
            chk("R6 no early cond", stop_n + rs_n, sb + rb);
            send_byte(pat(n, 0));
            #1;
            chk("R3 rxne", int'(rxne), 1);
            host_read("R3 data", pat(n, 0));
        end else if (n == 2) begin
            write_ctl(1'b0, 1'b1);
            send_byte(pat(n, 0));
            #1;
            chk("R3 rxne", int'(rxne), 1);
            chk("R3 btf low", int'(btf), 0);
            send_byte(pat(n, 1));
            #1;
            chk("R4 btf", int'(btf), 1);
            chk("R4 hold", int'(hold_scl), 1);
            for (int i = 0; i < 3; i++) begin
                bit_stb = 1'b1; bit_in = 1'b1; tick;
            end
            bit_stb = 1'b0; bit_in = 1'b0;
            request(mode);
            tick; tick; #1;
            chk("R6 waits for read", stop_n + rs_n, sb + rb);
            chk("R4 still held", int'(hold_scl), 1);
            host_read("R5 first data", pat(n, 0));
            tick; #1;
            chk("R5 btf cleared", int'(btf), 0);
            chk("R5 rxne kept", int'(rxne), 1);
            chk("R9 pos cleared", int'(pos_q), 0);
            host_read("R4 parked data intact", pat(n, 1));
            #1;
            chk("R5 rxne cleared", int'(rxne), 0);
        end else begin
            write_ctl(1'b1, 1'b0);
            for (int k = 0; k <= n - 4; k++) begin
                send_byte(pat(n, k));
                host_read("R3 data", pat(n, k));
            end
            send_byte(pat(n, n - 3));
            send_byte(pat(n, n - 2));
            #1;
            chk("R8 btf at three left", int'(btf), 1);
            write_ctl(1'b0, 1'b0);
            host_read("R8 data", pat(n, n - 3));
            #1;
            chk("R5 hold released", int'(hold_scl), 0);
            send_byte(pat(n, n - 1));
            #1;
            chk("R8 btf at end", int'(btf), 1);
            request(mode);
            host_read("R8 data", pat(n, n - 2));
            tick; #1;
            chk("R8 stop after first of last two", stop_n + rs_n, sb + rb + 1);
            host_read("R8 data", pat(n, n - 1));
        end
        tick; #1;
        chk({tag, " ack count"}, ack_n - ab, n);
        for (int k = 0; k < n; k++)
            chk({tag, " ack value"}, int'(ack_log[8'(ab + k)]), (k == n - 1) ? 1 : 0);
        chk("R6 stop count", stop_n - sb, (mode == 1) ? 0 : 1);
        chk("R6 restart count", rs_n - rb, (mode == 1) ? 1 : 0);
        chk("R5 drained", int'(rxne), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick; tick;
        rst = 1'b0;
        tick; #1;
        chk("R10 rxne", int'(rxne), 0);
        chk("R10 btf", int'(btf), 0);
        chk("R10 hold", int'(hold_scl), 0);
        chk("R10 ack_stb", int'(ack_stb), 0);
        chk("R10 cond", int'(gen_stop) + int'(gen_restart), 0);
        chk("R10 ctl", int'(ack_en_q) + int'(pos_q), 0);
        chk("R10 data", int'(dr_data), 0);

        // R1: live acknowledge-enable with delay bit clear
        write_ctl(1'b1, 1'b0);
        send_byte(8'h96);
        #1;
        chk("R1 ack_stb", int'(ack_stb), 1);
        chk("R1 ack value", int'(ack_nack), 0);
        host_read("R3 data", 8'h96);
        write_ctl(1'b0, 1'b0);
        send_byte(8'h41);
        #1;
        chk("R1 nack value", int'(ack_nack), 1);
        host_read("R3 data", 8'h41);
        tick; #1;
        chk("R1 single pulse", int'(ack_stb), 0);

        for (int n = 1; n <= 6; n++)
            for (int m = 0; m < 3; m++)
                run_read(n, m);

        // R9: disable clears control bits
        write_ctl(1'b1, 1'b1);
        #1;
        chk("R9 pos set", int'(pos_q), 1);
        enable = 1'b0;
        tick; #1;
        chk("R9 pos cleared by disable", int'(pos_q), 0);
        chk("R9 ack cleared by disable", int'(ack_en_q), 0);
        enable = 1'b1;
        tick;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule